// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block is one slice of a priority interrupt controller that can serve as either the cascade master or a cascade slave. Each slice captures rising edges on its request lines into a pending register. It keeps a record of the levels currently being serviced and resolves a fixed priority, with line 0 the most urgent. It raises its interrupt output whenever a pending request may preempt the work already in service. Mode selection arrives as static inputs. There is no command decoding, no polling, no rotation and no tri-state bus.

The processor answers an interrupt with a train of active-low acknowledge pulses. The pulse input is sampled by the free-running clock, and every register update happens in the cycle that sees a pulse edge. The master claims its winning line on the first pulse. When that line has a slave behind it, the master publishes the line number as a cascade address at the end of the first pulse and holds it until the sequence ends. The addressed slave claims its own winner on the second pulse and returns the vector: two bytes over a three-pulse sequence, or one byte over a two-pulse sequence. A master line with no slave behind it is answered by the master itself, with the same byte timing. The interrupt is retired by one end-of-interrupt command to each slice that claimed it. An optional nested mode on the master lets a slave that is already in service preempt again with a more urgent request.

Top module: `casc_ack_pic`

## Requirements
- R1: After reset, intOut, doutValid and casOutValid are 0, and the pending and in-service registers are empty.
- R2: A rising edge on irqReq[i] makes line i pending, and intOut rises in the cycle after the edge is sampled. Among eligible lines the lowest index wins.
- R3: In normal nesting, a pending line whose index is equal to or greater than the lowest in-service index does not raise intOut. A lower index does.
- R4: On the master, the first falling nInta edge of a sequence sets the winner's in-service bit and clears its pending bit. doutValid stays 0 for the whole first pulse.
- R5: When the master's winner is a line with cascadeInputs set, the first rising nInta edge drives casOut with the line index and sets casOutValid. casOutValid stays 1 until the rising edge of the last pulse, then returns to 0.
- R6: A slave claims only on the second falling edge, and only when casInValid is 1 and casIn equals ownCasAddr. An unaddressed slave drives no byte and keeps its request pending.
- R7: The vector word is vectorBase + level, 16 bits wide. In three-pulse mode (threePulse=1), the owner drives vector bits [7:0] on the second falling edge and bits [15:8] on the third. doutValid is 1 from each of these falls until the next rising edge.
- R8: In two-pulse mode (threePulse=0), the owner drives vector bits [7:0] on the second falling edge, and the sequence ends on the second rising edge.
- R9: An eoi pulse clears only the lowest-index in-service bit of the slice that receives it. Each slice must be sent its own eoi.
- R10: With specialNested=1 on the master, a pending request on the lowest-index in-service line raises intOut. A slave ignores specialNested.
- R11: When the master's winner has cascadeInputs clear, casOutValid stays 0 and the master drives the vector bytes itself on the second and third pulses.
- R12: A claim with no eligible request uses level NUM_IRQ-1 (7) for the vector and sets no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Active-low synchronous reset |
| isMaster | input | 1 | 1 = cascade master, 0 = slave |
| threePulse | input | 1 | 1 = three-pulse, 16-bit vector; 0 = two-pulse, 8-bit vector |
| specialNested | input | 1 | Special nested priority (honoured on the master only) |
| cascadeInputs | input | 8 | Master lines that have a slave attached |
| vectorBase | input | 16 | Base added to the level to form the vector |
| ownCasAddr | input | 3 | Cascade address of this slice as a slave |
| irqReq | input | 8 | Request lines, rising-edge captured |
| nInta | input | 1 | Active-low acknowledge pulse |
| casIn | input | 3 | Cascade address from the master |
| casInValid | input | 1 | casIn is valid |
| eoi | input | 1 | End-of-interrupt pulse |
| intOut | output | 1 | Interrupt request to the processor or master |
| casOut | output | 3 | Cascade address of the claimed slave line |
| casOutValid | output | 1 | casOut is valid |
| dout | output | 8 | Vector byte |
| doutValid | output | 1 | dout carries a vector byte |

## Verification
The assertions check on every cycle that in-service bits appear only in claim cycles and that the first pulse leaves the vector bus idle. They also check that the cascade address rises and falls only on the expected pulse edges, that a slave never drives it, that it never coincides with a vector byte, and that an end-of-interrupt retires exactly one level. Only the bench scenarios show the cross-slice behaviour. A master and a slave are chained there, so the scenarios exercise the priority order, the byte values and their order on the bus, nesting with and without the special mode, an unaddressed slave, the master answering for itself, and the spurious claim.

// File: rtl/casc_ack_pkg.sv
package casc_ack_pkg;
  // strobes from the acknowledge controller to the datapath
  typedef struct packed {
    logic claim;     // take the winner into service
    logic byteLo;    // second falling edge
    logic byteHi;    // third falling edge (three-pulse only)
    logic casShow;   // first rising edge on a master
    logic pulseRise; // any rising edge
    logic seqEnd;    // rising edge of the last pulse
  } ackStrobes_t;
endpackage

// File: rtl/casc_ack_ctrl.sv
module casc_ack_ctrl
  import casc_ack_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             nInta,
  input  logic             isMaster,
  input  logic             threePulse,
  input  logic [LVL_W-1:0] casIn,
  input  logic             casInValid,
  input  logic [LVL_W-1:0] ownCasAddr,
  output ackStrobes_t      stb
);
  localparam logic [1:0] CNT_MAX = 2'd3;

  logic       intaPrev;
  logic [1:0] pulseCnt;
  logic       fallEdge, riseEdge, addressed;
  logic [1:0] lastCnt;

  always_comb begin
    fallEdge  = intaPrev & ~nInta;
    riseEdge  = ~intaPrev & nInta;
    lastCnt   = threePulse ? 2'd3 : 2'd2;
    addressed = casInValid && (casIn == ownCasAddr);

    stb.claim     = fallEdge && (isMaster ? (pulseCnt == 2'd0)
                                          : (pulseCnt == 2'd1 && addressed));
    stb.byteLo    = fallEdge && (pulseCnt == 2'd1);
    stb.byteHi    = fallEdge && (pulseCnt == 2'd2) && threePulse;
    stb.casShow   = riseEdge && (pulseCnt == 2'd1) && isMaster;
    stb.pulseRise = riseEdge;
    stb.seqEnd    = riseEdge && (pulseCnt == lastCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intaPrev <= 1'b1;
      pulseCnt <= 2'd0;
    end else begin
      intaPrev <= nInta;
      if (stb.seqEnd)
        pulseCnt <= 2'd0;
      else if (fallEdge && pulseCnt != CNT_MAX)
        pulseCnt <= pulseCnt + 2'd1;
    end
  end
endmodule

// File: rtl/casc_ack_dp.sv
module casc_ack_dp
  import casc_ack_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int BYTE_W  = 8,
  parameter int LVL_W   = $clog2(NUM_IRQ),
  parameter int VEC_W   = 2 * BYTE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ackStrobes_t        stb,
  input  logic               isMaster,
  input  logic               specialNested,
  input  logic [NUM_IRQ-1:0] cascadeInputs,
  input  logic [VEC_W-1:0]   vectorBase,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               eoi,
  output logic               intOut,
  output logic [LVL_W-1:0]   casOut,
  output logic               casOutValid,
  output logic [BYTE_W-1:0]  dout,
  output logic               doutValid
);
  logic [NUM_IRQ-1:0] irr, isr, irqPrev, eligible, winOneHot, eoiMask;
  logic [LVL_W-1:0]   hiIdx, winIdx, claimLvl, lvlReg, lvlNow;
  logic               anyIsr, winValid, sfnmOn, claimCas, ownReg, ownNow, casPend;
  logic [VEC_W-1:0]   vecWord;

  // in-service level and priority resolution
  always_comb begin
    anyIsr = 1'b0;
    hiIdx  = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (isr[i]) begin
        anyIsr = 1'b1;
        hiIdx  = LVL_W'(i);
      end
    end
    sfnmOn = isMaster & specialNested;
    for (int i = 0; i < NUM_IRQ; i++) begin
      eligible[i] = irr[i] && (!anyIsr || LVL_W'(i) < hiIdx ||
                               (sfnmOn && LVL_W'(i) == hiIdx));
    end
    winValid = 1'b0;
    winIdx   = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        winValid = 1'b1;
        winIdx   = LVL_W'(i);
      end
    end
    winOneHot = winValid ? (NUM_IRQ'(1) << winIdx) : '0;
    eoiMask   = (eoi && anyIsr) ? (NUM_IRQ'(1) << hiIdx) : '0;
    intOut    = |eligible;

    claimCas = isMaster && winValid && cascadeInputs[winIdx];
    claimLvl = winValid ? winIdx : LVL_W'(NUM_IRQ - 1);
    ownNow   = stb.claim ? !claimCas : ownReg;
    lvlNow   = stb.claim ? claimLvl : lvlReg;
    vecWord  = vectorBase + VEC_W'(lvlNow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPrev     <= '0;
      irr         <= '0;
      isr         <= '0;
      lvlReg      <= '0;
      ownReg      <= 1'b0;
      casPend     <= 1'b0;
      casOut      <= '0;
      casOutValid <= 1'b0;
      dout        <= '0;
      doutValid   <= 1'b0;
    end else begin
      irqPrev <= irqReq;
      irr     <= (irr & ~(stb.claim ? winOneHot : '0)) | (irqReq & ~irqPrev);
      isr     <= (isr & ~eoiMask) | (stb.claim ? winOneHot : '0);

      if (stb.seqEnd) begin
        casOutValid <= 1'b0;
        casPend     <= 1'b0;
        ownReg      <= 1'b0;
      end
      if (stb.claim) begin
        lvlReg  <= claimLvl;
        ownReg  <= !claimCas;
        casPend <= claimCas;
      end
      if (stb.casShow && casPend) begin
        casOut      <= lvlReg;
        casOutValid <= 1'b1;
      end

      if (stb.byteLo && ownNow) begin
        dout      <= vecWord[BYTE_W-1:0];
        doutValid <= 1'b1;
      end else if (stb.byteHi && ownReg) begin
        dout      <= vecWord[VEC_W-1:BYTE_W];
        doutValid <= 1'b1;
      end else if (stb.pulseRise) begin
        doutValid <= 1'b0;
      end
    end
  end

  // new in-service bits appear only in a claim cycle
  assert_claim_sets_isr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|(isr & ~$past(isr))) |-> $past(stb.claim));

  // the master keeps the vector bus idle through the first pulse
  assert_first_pulse_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.claim && isMaster) |=> !doutValid);

  assert_cas_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(casOutValid) |-> $past(stb.casShow));

  assert_cas_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casOutValid) |-> $past(stb.seqEnd));

  assert_slave_no_cas_R6: assert property (@(posedge clk) disable iff (!rstN)
    !isMaster |-> !casOutValid);

  assert_cas_excl_dout_R11: assert property (@(posedge clk) disable iff (!rstN)
    casOutValid |-> !doutValid);

  assert_eoi_one_bit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (eoi && !stb.claim && anyIsr) |=> ($countones(isr) == $countones($past(isr)) - 1));
endmodule

// File: rtl/casc_ack_pic.sv
module casc_ack_pic
  import casc_ack_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int BYTE_W  = 8,
  localparam int LVL_W  = $clog2(NUM_IRQ),
  localparam int VEC_W  = 2 * BYTE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               isMaster,
  input  logic               threePulse,
  input  logic               specialNested,
  input  logic [NUM_IRQ-1:0] cascadeInputs,
  input  logic [VEC_W-1:0]   vectorBase,
  input  logic [LVL_W-1:0]   ownCasAddr,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               nInta,
  input  logic [LVL_W-1:0]   casIn,
  input  logic               casInValid,
  input  logic               eoi,
  output logic               intOut,
  output logic [LVL_W-1:0]   casOut,
  output logic               casOutValid,
  output logic [BYTE_W-1:0]  dout,
  output logic               doutValid
);
  ackStrobes_t stb;

  casc_ack_ctrl #(.LVL_W(LVL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .nInta(nInta), .isMaster(isMaster),
    .threePulse(threePulse), .casIn(casIn), .casInValid(casInValid),
    .ownCasAddr(ownCasAddr), .stb(stb)
  );

  casc_ack_dp #(.NUM_IRQ(NUM_IRQ), .BYTE_W(BYTE_W), .LVL_W(LVL_W), .VEC_W(VEC_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .isMaster(isMaster),
    .specialNested(specialNested), .cascadeInputs(cascadeInputs),
    .vectorBase(vectorBase), .irqReq(irqReq), .eoi(eoi), .intOut(intOut),
    .casOut(casOut), .casOutValid(casOutValid), .dout(dout), .doutValid(doutValid)
  );
endmodule

// File: tb/tb_casc_ack_pic.sv
`timescale 1ns/1ps
module tb_casc_ack_pic;
  localparam logic [15:0] M_BASE = 16'hA5C8;
  localparam logic [15:0] S_BASE = 16'h3B70;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, threePulse = 1'b1, specialNested = 1'b0, nInta = 1'b1;
  logic mEoi = 1'b0, sEoi = 1'b0;
  logic [7:0] mIrqTb = '0, sIrq = '0;
  logic [2:0] slvAddr = 3'd2;
  logic mInt, sInt, casValid, sCasValid, mDv, sDv;
  logic [2:0] casBus, sCasOut;
  logic [7:0] mDout, sDout;
  wire  [7:0] mIrq = {mIrqTb[7:3], sInt, mIrqTb[1:0]};

  casc_ack_pic dut (
    .clk(clk), .rstN(rstN), .isMaster(1'b1), .threePulse(threePulse),
    .specialNested(specialNested), .cascadeInputs(8'h04), .vectorBase(M_BASE),
    .ownCasAddr(3'd0), .irqReq(mIrq), .nInta(nInta), .casIn(3'd0),
    .casInValid(1'b0), .eoi(mEoi), .intOut(mInt), .casOut(casBus),
    .casOutValid(casValid), .dout(mDout), .doutValid(mDv)
  );

  casc_ack_pic slv (
    .clk(clk), .rstN(rstN), .isMaster(1'b0), .threePulse(threePulse),
    .specialNested(specialNested), .cascadeInputs(8'h00), .vectorBase(S_BASE),
    .ownCasAddr(slvAddr), .irqReq(sIrq), .nInta(nInta), .casIn(casBus),
    .casInValid(casValid), .eoi(sEoi), .intOut(sInt), .casOut(sCasOut),
    .casOutValid(sCasValid), .dout(sDout), .doutValid(sDv)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { bit dev; logic [7:0] val; string req; } exp_t;
  exp_t expQ[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver side of the scoreboard: dev 1 = master, 0 = slave
  task automatic expectByte(input bit dev, input logic [7:0] val, input string req);
    exp_t e;
    e.dev = dev; e.val = val; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic popCompare(input bit dev, input logic [7:0] val);
    exp_t e;
    if (expQ.size() == 0) begin
      chk("R6", "unexpected byte", int'(val), -1);
    end else begin
      e = expQ.pop_front();
      chk(e.req, "byte source", int'(dev), int'(e.dev));
      chk(e.req, "byte value", int'(val), int'(e.val));
    end
  endtask

  // monitor side of the scoreboard
  logic mDvQ = 1'b0, sDvQ = 1'b0;
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (mDv && !mDvQ) popCompare(1'b1, mDout);
      if (sDv && !sDvQ) popCompare(1'b0, sDout);
      if (mDv && sDv) chk("R6", "both slices drive", 1, 0);
    end
    mDvQ = mDv;
    sDvQ = sDv;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseLow();
    @(negedge clk) nInta = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseHigh();
    @(negedge clk) nInta = 1'b1;
    @(negedge clk);
  endtask

  task automatic resetDut(input logic three, input logic [2:0] addr);
    @(negedge clk);
    rstN = 1'b0; nInta = 1'b1; sIrq = '0; mIrqTb = '0;
    mEoi = 1'b0; sEoi = 1'b0; specialNested = 1'b0;
    threePulse = three; slvAddr = addr;
    tick(3);
    rstN = 1'b1;
    tick(2);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  logic [15:0] v;
  initial begin
    // cascaded three-pulse sequence, nesting and EOI
    resetDut(1'b1, 3'd2);
    chk("R1", "master intOut", int'(mInt), 0);
    chk("R1", "slave intOut", int'(sInt), 0);
    chk("R1", "master doutValid", int'(mDv), 0);
    chk("R1", "slave doutValid", int'(sDv), 0);
    chk("R1", "casOutValid", int'(casValid), 0);

    sIrq = 8'h60; tick(4); sIrq = '0;
    chk("R2", "slave intOut", int'(sInt), 1);
    chk("R2", "master intOut", int'(mInt), 1);
    v = S_BASE + 16'd5;
    expectByte(1'b0, v[7:0], "R7");
    expectByte(1'b0, v[15:8], "R7");
    pulseLow();
    chk("R4", "master doutValid pulse1", int'(mDv), 0);
    chk("R4", "master intOut after claim", int'(mInt), 0);
    chk("R5", "cas before rise", int'(casValid), 0);
    pulseHigh();
    chk("R5", "casOutValid", int'(casValid), 1);
    chk("R5", "casOut", int'(casBus), 2);
    pulseLow();
    chk("R5", "cas held pulse2", int'(casValid), 1);
    chk("R7", "slave doutValid pulse2", int'(sDv), 1);
    pulseHigh();
    chk("R7", "doutValid after rise", int'(sDv), 0);
    pulseLow();
    chk("R7", "slave doutValid pulse3", int'(sDv), 1);
    pulseHigh();
    chk("R5", "cas released", int'(casValid), 0);
    chk("R3", "slave lower level blocked", int'(sInt), 0);

    sIrq = 8'h20; tick(3); sIrq = '0;
    specialNested = 1'b1; tick(2);
    chk("R10", "slave ignores special mode", int'(sInt), 0);
    specialNested = 1'b0;
    sEoi = 1'b1; tick(1); sEoi = 1'b0; tick(4);
    chk("R9", "slave intOut after eoi", int'(sInt), 1);
    chk("R3", "master same level blocked", int'(mInt), 0);
    specialNested = 1'b1; tick(1);
    chk("R10", "master special nested", int'(mInt), 1);
    specialNested = 1'b0; tick(1);
    chk("R3", "master blocked again", int'(mInt), 0);
    mEoi = 1'b1; tick(1); mEoi = 1'b0; tick(2);
    chk("R9", "master intOut after eoi", int'(mInt), 1);
    chk("R7", "bytes outstanding", expQ.size(), 0);

    // two-pulse single-byte sequence
    resetDut(1'b0, 3'd2);
    sIrq = 8'h02; tick(4); sIrq = '0;
    v = S_BASE + 16'd1;
    expectByte(1'b0, v[7:0], "R8");
    pulseLow(); pulseHigh();
    chk("R8", "cas shown", int'(casValid), 1);
    pulseLow();
    chk("R8", "slave doutValid", int'(sDv), 1);
    pulseHigh();
    chk("R8", "cas released after 2nd rise", int'(casValid), 0);
    chk("R8", "doutValid cleared", int'(sDv), 0);
    chk("R8", "bytes outstanding", expQ.size(), 0);

    // unaddressed slave
    resetDut(1'b1, 3'd3);
    sIrq = 8'h10; tick(4); sIrq = '0;
    chk("R2", "master intOut via slave", int'(mInt), 1);
    for (int p = 0; p < 3; p++) begin
      pulseLow();
      chk("R6", "unaddressed slave silent", int'(sDv), 0);
      pulseHigh();
    end
    chk("R6", "slave request kept", int'(sInt), 1);

    // master line without a slave
    resetDut(1'b1, 3'd2);
    mIrqTb = 8'h01; tick(3); mIrqTb = '0;
    v = M_BASE + 16'd0;
    expectByte(1'b1, v[7:0], "R11");
    expectByte(1'b1, v[15:8], "R11");
    pulseLow();
    chk("R4", "master quiet pulse1", int'(mDv), 0);
    pulseHigh();
    chk("R11", "no cascade address", int'(casValid), 0);
    pulseLow();
    chk("R11", "master doutValid", int'(mDv), 1);
    pulseHigh(); pulseLow(); pulseHigh();
    chk("R11", "bytes outstanding", expQ.size(), 0);

    // spurious acknowledge
    resetDut(1'b0, 3'd2);
    v = M_BASE + 16'd7;
    expectByte(1'b1, v[7:0], "R12");
    pulseLow(); pulseHigh(); pulseLow();
    chk("R12", "spurious byte driven", int'(mDv), 1);
    pulseHigh();
    mIrqTb = 8'h80; tick(3); mIrqTb = '0;
    chk("R12", "level 7 not in service", int'(mInt), 1);
    chk("R12", "bytes outstanding", expQ.size(), 0);

    finishRun();
  end
endmodule